// File: doc/BRIEF.md
# Save-Area Alias Address Corrector

A memory error log can record an internal save-area alias where the physical DRAM address belongs. This block takes such a logged 64-bit address and returns the physical address. After a start strobe it checks the alias tag in the middle of the address. An address without the tag is returned unchanged, and no register reads take place. A tagged address starts a short sequence of configuration reads over a request/response port. The first read, made only when the caller does not already know the reporting node, finds that node through a policy register of the node that issued the save. The next read fetches the reporting node's DRAM limit register. In interleaved systems a further read fetches its DRAM base register.

From the limit register the block forms the base address of the save area and the interleave width. It then rebuilds the physical address in one of two ways. In the plain case it adds the low 24 logged bits to the base. In the interleaved case it spreads the logged page bits apart and inserts the node-select bits. A result is marked by a one-cycle valid pulse. An interleave setting that is not supported gives a one-cycle configuration-error pulse instead.

Top module: `addr_alias_fix`

## Requirements
- R1: A logged address is an alias only when its bits 47:24 equal 24'h00FDF7, and `aliasHit` then reads 1. Any other address appears unchanged on `fixAddr` with `aliasHit` 0 and no read request. `fixValid` pulses on the second rising edge after the edge that samples `start`.
- R2: When `nodeKnown` is 0 the source node is logged bits 22:20. A policy read (`rdSel` = 0) is made to that node, and the reporting node is taken from bits 14:12 of the returned data.
- R3: When `nodeKnown` is 1 no policy read is made, and `knownNode` is used as the reporting node.
- R4: The limit register (`rdSel` = 1) and, when interleaved, the base register (`rdSel` = 2) are read from the reporting node. The base read happens only when interleaving is enabled.
- R5: The save-area base is 48 bits wide. It is formed as {limit[20:0], limit[23:21] XOR 3'b111, 24'h000000}, and interleaving is on when limit[23:21] is nonzero.
- R6: Without interleaving the result is the save-area base plus logged bits 23:0.
- R7: With interleave field 1, 3 or 7, let k be 1, 2 or 3 respectively. The result is the save-area base plus an offset built from three parts. Logged bits 23:12 move to start at bit 12+k. The low k bits of base register bits 10:8 sit at bits 12+k-1:12. Logged bits 11:0 stay where they are.
- R8: Any other nonzero interleave field gives a one-cycle `cfgErr` pulse, and `fixValid` is not asserted for that request.
- R9: `rdReq` stays high, with `rdNode` and `rdSel` held stable, until `rdValid` arrives. Only one read is outstanding at a time.
- R10: `fixValid` is a one-cycle pulse. The block then returns to idle, and bits 63:48 of a corrected address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin correcting `logAddr` |
| logAddr | input | 64 | Logged error address |
| nodeKnown | input | 1 | Reporting node is supplied on `knownNode` |
| knownNode | input | 3 | Reporting node when `nodeKnown` is 1 |
| rdReq | output | 1 | Configuration read request |
| rdNode | output | 3 | Node addressed by the read |
| rdSel | output | 2 | Register select: 0 policy, 1 limit, 2 base |
| rdData | input | 24 | Read response data |
| rdValid | input | 1 | Read response valid pulse |
| fixAddr | output | 64 | Corrected or passed-through address |
| fixValid | output | 1 | Result valid pulse |
| aliasHit | output | 1 | Last request carried the alias tag |
| cfgErr | output | 1 | Unsupported interleave setting pulse |

## Verification
Two functions can fall in the same clock edge. One is a read response being accepted. The other is the sequencer raising the request that response answers, since the responder can answer a zero-wait read on the very first edge the request is high. The bench runs the same alias address once with a zero-wait responder and once with a five-cycle responder. In both runs it checks the final address, the number of reads and the node of each read. Under the slow responder it also confirms that the request, node and register select stay unchanged while the read waits.

// File: rtl/addr_alias_fix_pkg.sv
package addr_alias_fix_pkg;
  localparam int ADDR_W    = 64;
  localparam int PHYS_W    = 48;
  localparam int NODE_W    = 3;
  localparam int DATA_W    = 24;
  localparam int TAG_W     = 24;
  localparam int SEG_LSB   = 24;
  localparam int PAGE_LSB  = 12;
  localparam int LIM_W     = 21;
  localparam int IVL_LSB   = 21;
  localparam int POL_LSB   = 12;
  localparam int NSEL_LSB  = 8;
  localparam int SRC_LSB   = 20;
  localparam logic [TAG_W-1:0] ALIAS_TAG = 24'h00FDF7;

  typedef enum logic [1:0] {
    SEL_POLICY = 2'd0,
    SEL_LIMIT  = 2'd1,
    SEL_BASE   = 2'd2
  } regSel_e;

  typedef struct packed {
    logic captureLog;
    logic setAlias;
    logic loadKnown;
    logic loadPolicy;
    logic loadLimit;
    logic loadBase;
    logic passResult;
    logic loadResult;
  } ctrlStrobe_t;
endpackage

// File: rtl/addr_alias_fix_dp.sv
module addr_alias_fix_dp
  import addr_alias_fix_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  regSel_e             rdSel,
  input  logic [ADDR_W-1:0]   logAddr,
  input  logic                nodeKnown,
  input  logic [NODE_W-1:0]   knownNode,
  input  logic [DATA_W-1:0]   rdData,
  output logic                isAlias,
  output logic                knownQ,
  output logic [NODE_W-1:0]   intlvField,
  output logic [NODE_W-1:0]   rdNode,
  output logic [ADDR_W-1:0]   fixAddr,
  output logic                aliasHit
);
  localparam int HI_PAD = ADDR_W - PHYS_W;
  localparam int PAGE_W = SEG_LSB - PAGE_LSB;

  logic [ADDR_W-1:0] logQ;
  logic [NODE_W-1:0] knownNodeQ;
  logic [NODE_W-1:0] repNode;
  logic [DATA_W-1:0] limitQ;
  logic [NODE_W-1:0] baseSelQ;

  logic [PHYS_W-1:0] saveBase;
  logic [PHYS_W-1:0] flatOffs;
  logic [PHYS_W-1:0] spreadOffs;
  logic [PHYS_W-1:0] physSum;
  logic [NODE_W-1:0] selMask;
  logic [1:0]        shiftK;
  logic [NODE_W-1:0] srcNode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logQ       <= '0;
      knownQ     <= 1'b0;
      knownNodeQ <= '0;
    end else if (strb.captureLog) begin
      logQ       <= logAddr;
      knownQ     <= nodeKnown;
      knownNodeQ <= knownNode;
    end
  end

  assign isAlias    = (logQ[PHYS_W-1:SEG_LSB] == ALIAS_TAG);
  assign srcNode    = logQ[SRC_LSB +: NODE_W];
  assign intlvField = limitQ[IVL_LSB +: NODE_W];
  assign rdNode     = (rdSel == SEL_POLICY) ? srcNode : repNode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      repNode  <= '0;
      limitQ   <= '0;
      baseSelQ <= '0;
    end else begin
      if (strb.loadKnown)  repNode  <= knownNodeQ;
      if (strb.loadPolicy) repNode  <= rdData[POL_LSB +: NODE_W];
      if (strb.loadLimit)  limitQ   <= rdData;
      if (strb.loadBase)   baseSelQ <= rdData[NSEL_LSB +: NODE_W];
    end
  end

  always_comb begin
    case (intlvField)
      3'd1:    shiftK = 2'd1;
      3'd3:    shiftK = 2'd2;
      3'd7:    shiftK = 2'd3;
      default: shiftK = 2'd0;
    endcase
  end

  assign selMask  = NODE_W'((4'b0001 << shiftK) - 4'b0001);
  assign saveBase = {limitQ[LIM_W-1:0], limitQ[IVL_LSB +: NODE_W] ^ {NODE_W{1'b1}},
                     {SEG_LSB{1'b0}}};
  assign flatOffs = PHYS_W'(logQ[SEG_LSB-1:0]);

  always_comb begin
    spreadOffs = PHYS_W'(logQ[SEG_LSB-1:PAGE_LSB]) << (PAGE_LSB + int'(shiftK));
    spreadOffs = spreadOffs | (PHYS_W'(baseSelQ & selMask) << PAGE_LSB);
    spreadOffs = spreadOffs | PHYS_W'(logQ[PAGE_LSB-1:0]);
  end

  assign physSum = saveBase + ((intlvField == '0) ? flatOffs : spreadOffs);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fixAddr  <= '0;
      aliasHit <= 1'b0;
    end else begin
      if (strb.captureLog)      aliasHit <= 1'b0;
      else if (strb.setAlias)   aliasHit <= isAlias;
      if (strb.passResult)      fixAddr  <= logQ;
      else if (strb.loadResult) fixAddr  <= {{HI_PAD{1'b0}}, physSum};
    end
  end

  assert_upper_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadResult |=> fixAddr[ADDR_W-1:PHYS_W] == '0);

  assert_no_pass_on_alias_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.passResult && !strb.captureLog) |=> !aliasHit);
endmodule

// File: rtl/addr_alias_fix_ctrl.sv
module addr_alias_fix_ctrl
  import addr_alias_fix_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isAlias,
  input  logic              knownQ,
  input  logic [NODE_W-1:0] intlvField,
  input  logic              rdValid,
  output ctrlStrobe_t       strb,
  output logic              rdReq,
  output regSel_e           rdSel,
  output logic              fixValid,
  output logic              cfgErr
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RDPOL, ST_RDLIM, ST_EVAL, ST_RDBASE, ST_CALC, ST_DONE
  } state_e;

  state_e state, stateNext;
  logic   errQ, errNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      errQ  <= errNext;
    end
  end

  always_comb begin
    stateNext = state;
    errNext   = 1'b0;
    strb      = '0;
    rdReq     = 1'b0;
    rdSel     = SEL_LIMIT;
    case (state)
      ST_IDLE: if (start) begin
        strb.captureLog = 1'b1;
        stateNext       = ST_CHECK;
      end
      ST_CHECK: begin
        strb.setAlias = 1'b1;
        if (!isAlias) begin
          strb.passResult = 1'b1;
          stateNext       = ST_DONE;
        end else if (knownQ) begin
          strb.loadKnown = 1'b1;
          stateNext      = ST_RDLIM;
        end else begin
          stateNext = ST_RDPOL;
        end
      end
      ST_RDPOL: begin
        rdReq = 1'b1;
        rdSel = SEL_POLICY;
        if (rdValid) begin
          strb.loadPolicy = 1'b1;
          stateNext       = ST_RDLIM;
        end
      end
      ST_RDLIM: begin
        rdReq = 1'b1;
        rdSel = SEL_LIMIT;
        if (rdValid) begin
          strb.loadLimit = 1'b1;
          stateNext      = ST_EVAL;
        end
      end
      ST_EVAL: begin
        case (intlvField)
          3'd0:              stateNext = ST_CALC;
          3'd1, 3'd3, 3'd7:  stateNext = ST_RDBASE;
          default: begin
            errNext   = 1'b1;
            stateNext = ST_IDLE;
          end
        endcase
      end
      ST_RDBASE: begin
        rdReq = 1'b1;
        rdSel = SEL_BASE;
        if (rdValid) begin
          strb.loadBase = 1'b1;
          stateNext     = ST_CALC;
        end
      end
      ST_CALC: begin
        strb.loadResult = 1'b1;
        stateNext       = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign fixValid = (state == ST_DONE);
  assign cfgErr   = errQ;

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(rdSel)));

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    fixValid |=> !fixValid);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> !cfgErr);

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgErr && fixValid));
endmodule

// File: rtl/addr_alias_fix.sv
module addr_alias_fix
  import addr_alias_fix_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [63:0]       logAddr,
  input  logic              nodeKnown,
  input  logic [2:0]        knownNode,
  output logic              rdReq,
  output logic [2:0]        rdNode,
  output logic [1:0]        rdSel,
  input  logic [23:0]       rdData,
  input  logic              rdValid,
  output logic [63:0]       fixAddr,
  output logic              fixValid,
  output logic              aliasHit,
  output logic              cfgErr
);
  ctrlStrobe_t       strb;
  regSel_e           selInt;
  logic              isAlias;
  logic              knownQ;
  logic [NODE_W-1:0] intlvField;

  addr_alias_fix_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .isAlias    (isAlias),
    .knownQ     (knownQ),
    .intlvField (intlvField),
    .rdValid    (rdValid),
    .strb       (strb),
    .rdReq      (rdReq),
    .rdSel      (selInt),
    .fixValid   (fixValid),
    .cfgErr     (cfgErr)
  );

  addr_alias_fix_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdSel      (selInt),
    .logAddr    (logAddr),
    .nodeKnown  (nodeKnown),
    .knownNode  (knownNode),
    .rdData     (rdData),
    .isAlias    (isAlias),
    .knownQ     (knownQ),
    .intlvField (intlvField),
    .rdNode     (rdNode),
    .fixAddr    (fixAddr),
    .aliasHit   (aliasHit)
  );

  assign rdSel = selInt;

  assert_reads_only_alias_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> aliasHit);

  assert_node_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> $stable(rdNode));
endmodule

// File: tb/addr_alias_fix_tb.sv
module addr_alias_fix_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  localparam logic [63:0] V_ADDR [NVEC] = '{
    64'h0000_0012_3456_789A, 64'h0000_00FD_F7AB_CDEF, 64'h0000_00FD_F705_4321,
    64'h0000_00FD_F7FF_FFFF, 64'h0000_00FD_F712_3ABC, 64'h0000_00FD_F730_0001,
    64'h0000_00FD_F600_0000, 64'hABCD_00FD_F700_0000 };
  localparam logic V_NK [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [2:0] V_KN [NVEC] = '{3'd0, 3'd0, 3'd0, 3'd3, 3'd2, 3'd0, 3'd0, 3'd4};
  localparam logic [2:0] FLD [8] = '{3'd0, 3'd1, 3'd3, 3'd7, 3'd0, 3'd2, 3'd7, 3'd1};

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, nodeKnown = 1'b0, rdValid = 1'b0;
  logic [63:0] logAddr = '0;
  logic [2:0] knownNode = '0;
  logic [23:0] rdData = '0;
  logic rdReq, fixValid, aliasHit, cfgErr;
  logic [2:0] rdNode;
  logic [1:0] rdSel;
  logic [63:0] fixAddr;

  int checks = 0, errors = 0, cycles = 0;
  int readCount = 0, respDelay = 1;
  logic [2:0] polNodeSeen, limNodeSeen;
  logic [23:0] regFile [8][3];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_alias_fix u_dut (.clk(clk), .rstN(rstN), .start(start), .logAddr(logAddr),
    .nodeKnown(nodeKnown), .knownNode(knownNode), .rdReq(rdReq), .rdNode(rdNode),
    .rdSel(rdSel), .rdData(rdData), .rdValid(rdValid), .fixAddr(fixAddr),
    .fixValid(fixValid), .aliasHit(aliasHit), .cfgErr(cfgErr));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] repOf(input logic [2:0] n);
    return 3'((n * 3 + 1) % 8);
  endfunction

  // Independent model built from the requirement text
  function automatic void model(input logic [63:0] a, input logic nk, input logic [2:0] kn,
      output logic [63:0] e, output logic al, output logic er, output int rd,
      output logic [2:0] rn);
    logic [23:0] lim;
    logic [47:0] base, offs;
    int k;
    al = (a[47:24] == 24'h00FDF7);
    er = 1'b0; rd = 0; e = a;
    rn = nk ? kn : repOf(a[22:20]);
    if (!al) return;
    rd = nk ? 1 : 2;
    lim = regFile[rn][1];
    base = {lim[20:0], ~lim[23:21], 24'h0};
    case (lim[23:21])
      3'd0: k = 0;
      3'd1: k = 1;
      3'd3: k = 2;
      3'd7: k = 3;
      default: k = -1;
    endcase
    if (k < 0) begin er = 1'b1; return; end
    if (k == 0) e = {16'h0, base + {24'h0, a[23:0]}};
    else begin
      rd = rd + 1;
      offs = ({36'h0, a[23:12]} << (12 + k)) |
             ({45'h0, regFile[rn][2][10:8] & 3'((1 << k) - 1)} << 12) | {36'h0, a[11:0]};
      e = {16'h0, base + offs};
    end
  endfunction

  // Read responder with hold checks (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (rdReq) begin
        logic [2:0] n0;
        logic [1:0] s0;
        n0 = rdNode; s0 = rdSel;
        for (int i = 0; i < respDelay; i++) begin
          @(negedge clk);
          if (!(rdReq && rdNode == n0 && rdSel == s0)) begin
            checks++; errors++;
            $display("FAIL R9 actual=%b/%0d/%0d expected=1/%0d/%0d", rdReq, rdNode, rdSel, n0, s0);
          end
        end
        if (s0 == 2'd0) polNodeSeen = n0;
        if (s0 == 2'd1) limNodeSeen = n0;
        rdData = regFile[n0][s0];
        rdValid = 1'b1;
        readCount++;
        @(negedge clk);
        rdValid = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic runOp(input logic [63:0] a, input logic nk, input logic [2:0] kn,
      output int lat, output logic gotValid, output logic gotErr);
    @(negedge clk);
    logAddr = a; nodeKnown = nk; knownNode = kn; start = 1'b1;
    readCount = 0; polNodeSeen = 'x; limNodeSeen = 'x;
    @(negedge clk);
    start = 1'b0;
    lat = 1; gotValid = 0; gotErr = 0;
    while (!fixValid && !cfgErr && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    gotValid = fixValid; gotErr = cfgErr;
    @(negedge clk);
    check(gotErr ? "R8 err pulse" : "R10 valid pulse", {63'h0, fixValid | cfgErr}, 64'h0);
  endtask

  task automatic fullCheck(input logic [63:0] a, input logic nk, input logic [2:0] kn, input string tag);
    logic [63:0] e; logic al, er, gv, ge; int rd, lat; logic [2:0] rn;
    model(a, nk, kn, e, al, er, rd, rn);
    runOp(a, nk, kn, lat, gv, ge);
    check({tag, " R1 alias flag"}, {63'h0, aliasHit}, {63'h0, al});
    check({tag, " R8 err/valid"}, {62'h0, ge, gv}, {62'h0, er, !er});
    check({tag, " R4 read count"}, 64'(readCount), 64'(rd));
    if (!er) check({tag, " R6/R7 address"}, fixAddr, e);
    if (al) check({tag, " R4 limit node"}, {61'h0, limNodeSeen}, {61'h0, rn});
    if (al && !nk) check({tag, " R2 policy node"}, {61'h0, polNodeSeen}, {61'h0, a[22:20]});
    if (!al) check({tag, " R1 latency"}, 64'(lat), 64'd2);
  endtask

  initial begin
    for (int n = 0; n < 8; n++) begin
      regFile[n][0] = 24'h0 | (24'(repOf(3'(n))) << 12) | 24'hA0_0005;
      regFile[n][1] = {FLD[n], 21'(21'h0A5A5 ^ (n * 21'h01111))};
      regFile[n][2] = 24'h34_5800 | (24'(7 - n) << 8);
    end
    repeat (3) @(negedge clk);
    check("R10 reset fixAddr", fixAddr, 64'h0);
    check("R9 reset rdReq", {63'h0, rdReq}, 64'h0);
    check("R1 reset flags", {61'h0, fixValid, aliasHit, cfgErr}, 64'h0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) fullCheck(V_ADDR[v], V_NK[v], V_KN[v], "vec");

    // R3: known node overrides source bits, no policy read
    fullCheck(64'h0000_00FD_F770_0ABC, 1'b1, 3'd1, "R3 known");
    // R8: field 2 on node 5
    fullCheck(64'h0000_00FD_F700_1000, 1'b1, 3'd5, "R8 cfg");
    // R5: plain node 4, low bits all ones
    fullCheck(64'h0000_00FD_F7FF_FFFF, 1'b1, 3'd4, "R5 base");
    // R9: zero-wait and slow responders on the same interleaved alias
    respDelay = 0;
    fullCheck(64'h0000_00FD_F76A_5F0F, 1'b0, 3'd0, "R9 zero-wait");
    respDelay = 5;
    fullCheck(64'h0000_00FD_F76A_5F0F, 1'b0, 3'd0, "R9 slow");
    respDelay = 1;
    // R7: eight-way node 6 with all node-select bits set
    regFile[6][2] = 24'h00_0700;
    fullCheck(64'h0000_00FD_F7FF_F123, 1'b1, 3'd6, "R7 eight-way");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule